// File: doc/BRIEF.md
# Single-Port Synchronous RAM with Selectable Read-During-Write Behaviour

This block is a single-port synchronous memory. One address bus serves both reads and writes. The block has a write-data input, a write strobe, a read strobe that can be switched off, and one read-data output. The shape of the memory, meaning the word width and the number of words, is set by parameters. Elaboration accepts only nine shapes, all of them about nine kilobits in size. Any other shape stops elaboration with an error.

A read and a write can land on the same address in the same cycle. A mode parameter then decides what the output shows:

- the incoming word (new-data mode),
- the word that was stored before the write (old-data mode), or
- an unspecified value (don't-care mode).

While the read strobe is low, the output holds the last value it captured, and this includes cycles that write. An optional output register adds one cycle of latency.

A synchronous reset clears only the output path. Memory contents survive reset.

Top module: `spram_rdw`

## Requirements
- R1: Elaboration accepts only these width×depth pairs: 1×8192, 2×4096, 4×2048, 8×1024, 9×1024, 16×512, 18×512, 32×256 and 36×256. Any other pair causes an elaboration error.
- R2: A read cycle (`rd_en` high, `wr_en` low) shows the word stored at `addr` on `rd_data` after one rising edge, or after two when `OUT_REG` is 1.
- R3: A word written with `wr_en` high is returned by every later read of the same address until that address is written again.
- R4: When `USE_RD_EN` is 1 and `rd_en` is low, `rd_data` keeps its value, whether or not a write takes place.
- R5: With `RDW_MODE` set to new-data, a cycle with both strobes high shows the word being written.
- R6: With `RDW_MODE` set to old-data, a cycle with both strobes high shows the previous contents of the address. The written word is returned by later reads.
- R7: With `RDW_MODE` set to don't-care, the output of a same-cycle read and write is unspecified. The write still stores its word.
- R8: When `USE_RD_EN` is 0, `rd_en` has no effect and every cycle acts as a read.
- R9: When `OUT_REG` is 1, the output appears exactly one cycle later than the unregistered output.
- R10: A synchronous reset (`rst` high at an edge) drives `rd_data` to zero and clears the held value. It leaves memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all activity happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset for the output path |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; ignored when `USE_RD_EN` is 0 |
| addr | input | ADDR_W ($clog2(DEPTH)) | Shared read/write word address |
| wr_data | input | DATA_W | Word to be written |
| rd_data | output | DATA_W | Read word |

## Verification
Three instances run from the same stimulus:

- new-data mode, read strobe in use, no output register;
- old-data mode with the output register;
- don't-care mode with the read strobe disabled.

Writes issued with the read strobe low separate hold behaviour from ordinary reads. Same-cycle reads and writes separate new-data output from old-data output. Back-to-back reads in the registered instance expose an off-by-one latency.

Reads of the lowest and highest addresses confirm that the whole address range decodes. A reset placed in the middle of the run, followed by a read of earlier data, shows that reset clears the output but not the memory.

// File: rtl/spram_pkg.sv
package spram_pkg;

   typedef enum logic [1:0] {
      RDW_NEW      = 2'd0,
      RDW_OLD      = 2'd1,
      RDW_DONTCARE = 2'd2
   } rdw_mode_e;

   // Nine-kilobit-class shapes accepted by the RAM
   function automatic bit legal_shape(input int width, input int depth);
      case (width)
         1:       return depth == 8192;
         2:       return depth == 4096;
         4:       return depth == 2048;
         8, 9:    return depth == 1024;
         16, 18:  return depth == 512;
         32, 36:  return depth == 256;
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/spram_store.sv
module spram_store #(
   parameter int                   DATA_W   = 8,
   parameter int                   DEPTH    = 1024,
   parameter int                   ADDR_W   = 10,
   parameter spram_pkg::rdw_mode_e RDW_MODE = spram_pkg::RDW_NEW
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              rd_fire,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_q
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] stored;
   logic [DATA_W-1:0] rdw_word;

   always_ff @(posedge clk) begin
      if (wr_en) mem[addr] <= wr_data;
   end

   assign stored = mem[addr];

   generate
      if (RDW_MODE == spram_pkg::RDW_NEW) begin : g_new
         assign rdw_word = wr_en ? wr_data : stored;
      end else begin : g_old_or_dc
         // don't-care reuses the pre-write word: no extra mux
         assign rdw_word = stored;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)          rd_q <= '0;
      else if (rd_fire) rd_q <= rdw_word;
   end

endmodule

// File: rtl/spram_outstage.sv
module spram_outstage #(
   parameter int DATA_W  = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) dout <= '0;
            else     dout <= din;
         end
      end else begin : g_pass
         assign dout = din;
      end
   endgenerate

endmodule

// File: rtl/spram_rdw.sv
module spram_rdw #(
   parameter int                   DATA_W    = 8,
   parameter int                   DEPTH     = 1024,
   parameter spram_pkg::rdw_mode_e RDW_MODE  = spram_pkg::RDW_NEW,
   parameter bit                   USE_RD_EN = 1'b1,
   parameter bit                   OUT_REG   = 1'b0,
   localparam int                  ADDR_W    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);

   generate
      if (!spram_pkg::legal_shape(DATA_W, DEPTH)) begin : g_bad_shape
         $error("spram_rdw: width %0d x depth %0d is not a legal shape", DATA_W, DEPTH);
      end
   endgenerate

   logic              rd_fire;
   logic [DATA_W-1:0] core_q;

   assign rd_fire = !USE_RD_EN || rd_en;

   spram_store #(
      .DATA_W   (DATA_W),
      .DEPTH    (DEPTH),
      .ADDR_W   (ADDR_W),
      .RDW_MODE (RDW_MODE)
   ) u_store (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .rd_fire (rd_fire),
      .addr    (addr),
      .wr_data (wr_data),
      .rd_q    (core_q)
   );

   spram_outstage #(
      .DATA_W  (DATA_W),
      .OUT_REG (OUT_REG)
   ) u_out (
      .clk  (clk),
      .rst  (rst),
      .din  (core_q),
      .dout (rd_data)
   );

endmodule

// File: rtl/spram_rdw_chk.sv
module spram_rdw_chk #(
   parameter int                   DATA_W    = 8,
   parameter spram_pkg::rdw_mode_e RDW_MODE  = spram_pkg::RDW_NEW,
   parameter bit                   USE_RD_EN = 1'b1,
   parameter bit                   OUT_REG   = 1'b0
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic              rd_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] core_q,
   input logic [DATA_W-1:0] rd_data
);

   logic fire;
   assign fire = !USE_RD_EN || rd_en;

   // R4
   hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !fire |=> $stable(core_q));

   // R10
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (rd_data == '0 && core_q == '0));

   generate
      if (RDW_MODE == spram_pkg::RDW_NEW) begin : g_new_chk
         // R5
         new_data_chk: assert property (@(posedge clk) disable iff (rst)
            (fire && wr_en) |=> core_q == $past(wr_data));
      end
      if (OUT_REG) begin : g_lat_chk
         // R9
         out_delay_chk: assert property (@(posedge clk) disable iff (rst)
            !rst |=> rd_data == $past(core_q));
      end
   endgenerate

endmodule

bind spram_rdw spram_rdw_chk #(
   .DATA_W    (DATA_W),
   .RDW_MODE  (RDW_MODE),
   .USE_RD_EN (USE_RD_EN),
   .OUT_REG   (OUT_REG)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .wr_en   (wr_en),
   .rd_en   (rd_en),
   .wr_data (wr_data),
   .core_q  (core_q),
   .rd_data (rd_data)
);

// File: tb/spram_rdw_tb.sv
module spram_rdw_tb;

   localparam int DW = 8;
   localparam int DP = 1024;
   localparam int AW = 10;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] q_new, q_old, q_dc;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   spram_rdw #(.DATA_W(DW), .DEPTH(DP), .RDW_MODE(spram_pkg::RDW_NEW),
               .USE_RD_EN(1'b1), .OUT_REG(1'b0)) u_dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wr_data(wr_data), .rd_data(q_new));

   spram_rdw #(.DATA_W(DW), .DEPTH(DP), .RDW_MODE(spram_pkg::RDW_OLD),
               .USE_RD_EN(1'b1), .OUT_REG(1'b1)) u_dut_old (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wr_data(wr_data), .rd_data(q_old));

   spram_rdw #(.DATA_W(DW), .DEPTH(DP), .RDW_MODE(spram_pkg::RDW_DONTCARE),
               .USE_RD_EN(1'b0), .OUT_REG(1'b0)) u_dut_dc (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wr_data(wr_data), .rd_data(q_dc));

   // behavioural model
   logic [DW-1:0] m_mem [DP];
   logic [DW-1:0] e_new = '0, e_old = '0, e_oldq = '0, e_dc = '0;
   bit            dc_ok = 1'b1;

   // {wr_en, rd_en, addr, wr_data}
   localparam int NV = 15;
   localparam logic [19:0] VEC [NV] = '{
      {1'b1, 1'b0, 10'd3,    8'hA5},  // R3 R4 write, output holds
      {1'b1, 1'b0, 10'd7,    8'h3C},
      {1'b1, 1'b0, 10'd0,    8'h5A},  // lowest address
      {1'b1, 1'b0, 10'd1023, 8'hC3},  // highest address
      {1'b0, 1'b1, 10'd3,    8'h00},  // R2 read
      {1'b1, 1'b0, 10'd3,    8'h11},  // R4 write while idle
      {1'b1, 1'b1, 10'd3,    8'h22},  // R5 R6 R7 same-cycle
      {1'b0, 1'b1, 10'd3,    8'h00},  // R3 R6 new word stored
      {1'b1, 1'b1, 10'd7,    8'h44},
      {1'b0, 1'b0, 10'd7,    8'h00},  // R4 hold, R8 dc still reads
      {1'b0, 1'b1, 10'd1023, 8'h00},
      {1'b0, 1'b1, 10'd0,    8'h00},
      {1'b1, 1'b1, 10'd0,    8'h99},
      {1'b0, 1'b1, 10'd7,    8'h00},  // R7 dc memory updated
      {1'b0, 1'b1, 10'd0,    8'h00}
   };

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive just after a falling edge, model at rising edge, check at next falling edge
   task automatic cycle(input logic r, input logic we, input logic re,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
      logic [DW-1:0] prev;
      rst = r; wr_en = we; rd_en = re; addr = a; wr_data = d;
      @(posedge clk);
      if (r) begin
         e_new = '0; e_old = '0; e_oldq = '0; e_dc = '0; dc_ok = 1'b1;
      end else begin
         prev   = m_mem[a];
         e_oldq = e_old;
         if (re) begin
            e_new = we ? d : prev;
            e_old = prev;
         end
         e_dc  = prev;
         dc_ok = !we;
         if (we) m_mem[a] = d;
      end
      @(negedge clk);
      if (r) begin
         check("R10 new", q_new, e_new);
         check("R10 old", q_old, e_oldq);
         check("R10 dc",  q_dc,  e_dc);
      end else begin
         check((we && re) ? "R5 new" : (!re ? "R4 new" : "R2/R3 new"), q_new, e_new);
         check((we && re) ? "R6 old" : "R9 old", q_old, e_oldq);
         if (dc_ok) check(!re ? "R8 dc" : "R7 dc", q_dc, e_dc);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R1 shape rule
      check("R1 legal 8x1024",   DW'(spram_pkg::legal_shape(8, 1024)), DW'(1));
      check("R1 illegal 8x512",  DW'(spram_pkg::legal_shape(8, 512)),  DW'(0));
      check("R1 illegal 36x512", DW'(spram_pkg::legal_shape(36, 512)), DW'(0));
      @(negedge clk);
      cycle(1'b1, 1'b0, 1'b0, '0, '0);   // R10 reset state
      cycle(1'b1, 1'b0, 1'b0, '0, '0);
      for (int i = 0; i < NV; i++)
         cycle(1'b0, VEC[i][19], VEC[i][18], VEC[i][17:8], VEC[i][7:0]);
      // R10: mid-run reset clears outputs, keeps memory
      cycle(1'b1, 1'b0, 1'b1, 10'd3, '0);
      cycle(1'b0, 1'b0, 1'b0, 10'd3, '0);
      cycle(1'b0, 1'b0, 1'b1, 10'd3, '0);
      check("R10 memory kept", q_new, 8'h22);
      // R9 registered instance catches up one cycle later
      cycle(1'b0, 1'b0, 1'b0, 10'd3, '0);
      check("R9 delayed", q_old, 8'h22);
      cycle(1'b0, 1'b0, 1'b1, 10'd1023, '0);
      cycle(1'b0, 1'b0, 1'b1, 10'd0, '0);
      check("R9 back-to-back", q_old, 8'hC3);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule